// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Control

This block is the programmable feedback divider of a frequency synthesizer that sits behind an external dual-modulus prescaler of ratio P/P+1. Its clock is the prescaler output, so every rising edge stands for one prescaler output period. Two down-counters run side by side. The main count (`main_div`, 10 bits) sets the number of prescaler periods in one divider cycle. The swallow count (`swallow_cnt`, 6 bits) sets how many of those periods use the P+1 ratio. The modulus-control output `mod_sel` is low (P+1) while swallowing and high (P) for the rest of the cycle. The overall division from the oscillator is therefore main·P + swallow.

At the end of every cycle the block reloads both counters from the parallel programming inputs and drives a single-clock pulse on `div_out` toward the phase detector. The programming inputs are sampled only at the reload edge and at a synchronous reset, so a cycle never mixes two programmed values.

The controller is a two-state machine. `ST_SWALLOW` holds `mod_sel` low. `ST_MAIN` holds it high. Its transitions are:
- LOAD_SW: reload or reset with a nonzero swallow value, into `ST_SWALLOW`.
- LOAD_MAIN: reload or reset with a zero swallow value, into `ST_MAIN`.
- SW_DONE: the swallow count reaches zero, `ST_SWALLOW` to `ST_MAIN`.
- HOLD: no event, the state stays the same.

Reload has priority over SW_DONE.

Top module: `dmpsw_divider`

## Requirements
- R1: On a rising edge with `rst` high, both counters load from `n_prog`/`a_prog`. On the next edge `div_out` is low, and `mod_sel` is low unless `a_prog` was 0. No `div_out` pulse follows the reset edge itself.
- R2: Within a cycle of main value N and swallow value A (A < N), `mod_sel` is low for the first A clock periods after the cycle-start edge and high for the remaining N−A periods.
- R3: A divider cycle lasts exactly N rising edges, so consecutive `div_out` pulses are N clocks apart while the programming is unchanged.
- R4: `div_out` is high for exactly the one clock period that follows each reload edge. It is low at every other time, with one exception: when N is 1 every edge is a reload edge.
- R5: A change on `n_prog` or `a_prog` in the middle of a cycle has no effect on `mod_sel` or on the cycle length until the next reload edge.
- R6: When A is 0, `mod_sel` is high from the first period of the cycle and stays high for the whole cycle.
- R7: When A ≥ N, the reload takes priority, so `mod_sel` stays low for the whole cycle.
- R8: An `n_prog` value of 0 behaves as 1, giving a reload on every edge.
- R9: Counting P oscillator periods for each clock with `mod_sel` high and P+1 for each clock with it low, one cycle sums to N·P + A whenever A ≤ N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, one rising edge per prescaler period |
| rst | input | 1 | Synchronous reset, active high; loads counters and picks the start state |
| n_prog | input | 10 | Main division value, sampled at reload and reset |
| a_prog | input | 6 | Swallow count value, sampled at reload and reset |
| mod_sel | output | 1 | Modulus control: low selects P+1, high selects P |
| div_out | output | 1 | One-clock divided-output pulse at each cycle start |

## Verification
`mod_sel` and `div_out` both come from registers. Each one therefore shows the result of a rising edge during the clock period that immediately follows that edge, and no output changes later than one edge after its cause. The bench drives inputs and compares outputs on the falling edge, half a period after the producing edge. It keeps its own position counter within the cycle and updates it on every rising edge. That counter latches new programming values only on the edges where the requirements say a reload happens, so mid-cycle changes and resets are judged against the value that should be in force on that exact edge. The N·P + A sum is totalled from the observed `mod_sel` samples and compared when the bench's own cycle counter wraps.

// File: rtl/dmpsw_pkg.sv
package dmpsw_pkg;

    // Controller states: swallow phase (prescaler at P+1) and main phase (P)
    typedef enum logic {
        ST_SWALLOW = 1'b0,
        ST_MAIN    = 1'b1
    } dmpsw_state_t;

endpackage

// File: rtl/dmpsw_downcnt.sv
// Loadable down-counter with floor at zero and terminal flags.
module dmpsw_downcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         at_last,
    output logic         at_zero
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != ZERO)) begin
            cnt <= cnt - ONE;
        end
    end

    always_comb begin
        at_last = (cnt <= ONE);
        at_zero = (cnt == ZERO);
    end

endmodule

// File: rtl/dmpsw_seq_fsm.sv
// Swallow / main phase controller and divided-output pulse register.
module dmpsw_seq_fsm
    import dmpsw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic swallow_last,
    input  logic next_a_zero,
    output logic swallow_dec,
    output logic mod_sel,
    output logic div_out
);

    dmpsw_state_t state_q;
    dmpsw_state_t state_d;
    logic         pulse_q;

    // Next-state decision: reset/reload wins over swallow completion
    always_comb begin
        state_d = state_q;
        if (rst || reload) begin
            state_d = next_a_zero ? ST_MAIN : ST_SWALLOW;   // LOAD_MAIN / LOAD_SW
        end else begin
            unique case (state_q)
                ST_SWALLOW: if (swallow_last) state_d = ST_MAIN; // SW_DONE
                ST_MAIN:    state_d = ST_MAIN;                   // HOLD
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        pulse_q <= reload && !rst;
    end

    // Output process
    always_comb begin
        mod_sel     = (state_q == ST_MAIN);
        swallow_dec = (state_q == ST_SWALLOW);
        div_out     = pulse_q;
    end

endmodule

// File: rtl/dmpsw_divider.sv
// Dual-modulus pulse-swallow divider control, top level.
module dmpsw_divider #(
    parameter int NW = 10,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] n_prog,
    input  logic [AW-1:0] a_prog,
    output logic          mod_sel,
    output logic          div_out
);

    localparam logic [NW-1:0] N_MIN = NW'(1);

    logic [NW-1:0] n_cnt;
    logic [AW-1:0] a_cnt;
    logic [NW-1:0] n_load;
    logic          n_last;
    logic          n_zero_unused;
    logic          a_last;
    logic          a_zero;
    logic          a_dec;
    logic          reload;
    logic          cnt_load;

    // A programmed main value of zero is treated as one
    always_comb begin
        n_load   = (n_prog == '0) ? N_MIN : n_prog;
        reload   = n_last;
        cnt_load = rst || reload;
        a_last   = (a_cnt == AW'(1));
    end

    dmpsw_downcnt #(.W(NW)) u_main_cnt (
        .clk      (clk),
        .load     (cnt_load),
        .dec      (1'b1),
        .load_val (n_load),
        .cnt      (n_cnt),
        .at_last  (n_last),
        .at_zero  (n_zero_unused)
    );

    dmpsw_downcnt #(.W(AW)) u_swallow_cnt (
        .clk      (clk),
        .load     (cnt_load),
        .dec      (a_dec),
        .load_val (a_prog),
        .cnt      (a_cnt),
        .at_last  (),
        .at_zero  (a_zero)
    );

    dmpsw_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .reload       (reload),
        .swallow_last (a_last && !a_zero),
        .next_a_zero  (a_prog == '0),
        .swallow_dec  (a_dec),
        .mod_sel      (mod_sel),
        .div_out      (div_out)
    );

endmodule

// File: rtl/dmpsw_divider_chk.sv
// Property checker attached to the divider top.
module dmpsw_divider_chk #(
    parameter int NW = 10,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic [NW-1:0] n_prog,
    input logic [AW-1:0] a_prog,
    input logic          mod_sel,
    input logic          div_out,
    input logic [NW-1:0] n_cnt,
    input logic [AW-1:0] a_cnt
);

    // R1: the edge after a reset edge never carries a divided pulse
    a_r1_no_pulse_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !div_out);

    // R2: main phase is entered only after the swallow count is exhausted
    a_r2_main_after_swallow: assert property (@(posedge clk) disable iff (rst)
        mod_sel |-> (a_cnt == '0));

    // R2: modulus control returns low only at a cycle start
    a_r2_fall_at_reload: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel) |-> div_out);

    // R3: the main counter never sits at zero
    a_r3_main_nonzero: assert property (@(posedge clk) disable iff (rst)
        n_cnt != '0);

    // R4/R8: a pulse coincides with a fresh load of the main count
    a_r4_pulse_fresh_load: assert property (@(posedge clk) disable iff (rst)
        div_out |-> (n_cnt == (($past(n_prog) == '0) ? NW'(1) : $past(n_prog))));

    // R6: zero swallow starts the cycle in the main phase
    a_r6_zero_swallow_high: assert property (@(posedge clk) disable iff (rst)
        (div_out && ($past(a_prog) == '0)) |-> mod_sel);

    // R2/R7: nonzero swallow starts the cycle low
    a_r7_swallow_starts_low: assert property (@(posedge clk) disable iff (rst)
        (div_out && ($past(a_prog) != '0)) |-> !mod_sel);

endmodule

bind dmpsw_divider dmpsw_divider_chk #(.NW(NW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .n_prog  (n_prog),
    .a_prog  (a_prog),
    .mod_sel (mod_sel),
    .div_out (div_out),
    .n_cnt   (n_cnt),
    .a_cnt   (a_cnt)
);

// File: tb/dmpsw_divider_tb.sv
module dmpsw_divider_tb;

    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] n_prog = 10'd5;
    logic [5:0] a_prog = 6'd2;
    logic       mod_sel;
    logic       div_out;

    int checks = 0;
    int failures = 0;

    // bench model state
    int pos = 0;
    int cur_n = 1;
    int cur_a = 0;
    bit exp_pulse = 1'b0;
    bit started = 1'b0;
    int vco_sum = 0;
    int last_n = 1;
    int last_a = 0;

    always #10 clk = ~clk;

    dmpsw_divider u_dut (
        .clk     (clk),
        .rst     (rst),
        .n_prog  (n_prog),
        .a_prog  (a_prog),
        .mod_sel (mod_sel),
        .div_out (div_out)
    );

    // {n[23:14], a[13:8], clocks[7:0]}
    localparam logic [23:0] VEC [8] = '{
        {10'd5,  6'd2,  8'd30},
        {10'd10, 6'd3,  8'd40},
        {10'd4,  6'd0,  8'd20},
        {10'd6,  6'd6,  8'd24},
        {10'd3,  6'd9,  8'd15},
        {10'd1,  6'd0,  8'd8},
        {10'd17, 6'd16, 8'd60},
        {10'd63, 6'd40, 8'd140}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update model at the rising edge, compare at the falling edge
    task automatic step(input string mod_tag);
        @(posedge clk);
        if (rst) begin
            pos = 0;
            cur_n = (n_prog == 0) ? 1 : int'(n_prog);
            cur_a = int'(a_prog);
            exp_pulse = 1'b0;
            vco_sum = 0;
            started = 1'b1;
        end else begin
            pos = pos + 1;
            exp_pulse = 1'b0;
            if (pos >= cur_n) begin
                if (started && cur_a <= cur_n)
                    check("R9", vco_sum, cur_n * P + cur_a);
                last_n = cur_n;
                last_a = cur_a;
                pos = 0;
                cur_n = (n_prog == 0) ? 1 : int'(n_prog);
                cur_a = int'(a_prog);
                exp_pulse = 1'b1;
                vco_sum = 0;
            end
        end
        @(negedge clk);
        check(mod_tag, int'(mod_sel), (pos >= cur_a) ? 1 : 0);
        check("R4", int'(div_out), int'(exp_pulse));
        vco_sum += mod_sel ? P : P + 1;
    endtask

    task automatic do_reset(input logic [9:0] n, input logic [5:0] a);
        n_prog = n;
        a_prog = a;
        rst = 1'b1;
        step("R1");
        step("R1");
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int gap;
        int seen;
        @(negedge clk);

        // R1: reset state
        do_reset(10'd5, 6'd2);
        check("R1", int'(mod_sel), 0);
        check("R1", int'(div_out), 0);
        step("R1");
        check("R1", int'(div_out), 0);

        // table walk (R2, R6, R7 patterns)
        foreach (VEC[k]) begin
            do_reset(VEC[k][23:14], VEC[k][13:8]);
            for (int c = 0; c < int'(VEC[k][7:0]); c++) step("R2");
        end

        // R6: zero swallow, high from first period
        do_reset(10'd7, 6'd0);
        check("R6", int'(mod_sel), 1);
        for (int c = 0; c < 21; c++) step("R6");

        // R7: swallow larger than main keeps mod_sel low
        do_reset(10'd4, 6'd7);
        for (int c = 0; c < 16; c++) begin
            step("R7");
            check("R7", int'(mod_sel), 0);
        end

        // R8: zero main value behaves as one
        do_reset(10'd0, 6'd0);
        for (int c = 0; c < 6; c++) begin
            step("R8");
            check("R8", int'(div_out), 1);
        end

        // R5: mid-cycle programming change applies only at reload
        do_reset(10'd12, 6'd4);
        step("R5");
        step("R5");
        n_prog = 10'd3;
        a_prog = 6'd1;
        for (int c = 0; c < 9; c++) step("R5");
        check("R5", int'(div_out), 0);
        step("R5");
        check("R5", int'(div_out), 1);
        check("R5", int'(mod_sel), 0);
        for (int c = 0; c < 9; c++) step("R5");

        // R3: spacing between pulses equals N
        do_reset(10'd13, 6'd3);
        gap = 0;
        seen = 0;
        for (int c = 0; c < 60; c++) begin
            step("R3");
            gap++;
            if (div_out) begin
                if (seen > 0) check("R3", gap, 13);
                seen++;
                gap = 0;
            end
        end
        check("R3", seen, 4);

        // R1: reset in the middle of a cycle restarts it
        n_prog = 10'd9;
        a_prog = 6'd5;
        for (int c = 0; c < 4; c++) step("R2");
        do_reset(10'd6, 6'd2);
        check("R1", int'(mod_sel), 0);
        for (int c = 0; c < 18; c++) step("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule